// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block turns one request (an opcode, an optional column and an optional page address) into the latch phases of a small-page NAND flash. It drives the command-latch and address-latch strobes, the chip enable, the write-enable strobe and the 8-bit bus. Then it waits for the device to finish, and it pulses `done` when the request is complete. Data transfers and error correction are handled elsewhere. This block only sets the device up for them.

Two behaviours go beyond plain latching. First, a sequential-data-input request (0x80) is always preceded by a read-pointer command. That pointer command is picked by the region the column falls in, and the column is rebased into that region. Second, a read that carries a page address keeps chip enable low through the whole busy time. This read wait is bounded, while a reset or an unlisted opcode waits on ready without limit.

Each request passes through named states:
- IDLE to PTR (only for 0x80) or to CMD.
- CMD to COL, PG0 or the post-address step.
- COL to PG0 or the post-address step.
- PG0 to PG1.
- PG1 to PG2 (large devices) or the post-address step.
- PG2 to the post-address step.

The post-address step is either DONE (no-wait opcodes) or TWB. After that, TWB goes to WAIT, WAIT goes to DONE on ready or on timeout, and DONE goes to IDLE.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `busy`, `nand_cle`, `nand_ale` are 0, while `nand_ce_n` and `nand_we_n` are 1. A request is taken when `req_valid` and `req_ready` are both high at a clock edge. `busy` is then high and `req_ready` low until the cycle after the one-cycle `done` pulse.
- R2: The opcode byte is written with `nand_cle`=1 and `nand_ale`=0. The two strobes are never high together. Address bytes (`nand_ale`=1) appear only when `req_col_en` or `req_page_en` is set.
- R3: The address bytes go out in this order: the column byte (if enabled), then page[7:0], then page[15:8]. A fourth byte {4'b0, page[19:16]} follows only when `LARGE_DEV`=1.
- R4: For opcode 0x80, a pointer byte is written with `nand_cle`=1 before it. A column of `MAIN_BYTES` (512) or more gives pointer 0x50 and the column minus 512. A column below 256 gives pointer 0x00 and the column unchanged. Any other column gives pointer 0x01 and the column minus 256.
- R5: With `BUS16`=1, the column byte sent is the column (after any R4 rebase) shifted right by one bit.
- R6: Every byte is written with `nand_we_n` low for at least 2 clocks while `nand_ce_n` is 0. `nand_dq` stays stable from the falling edge of `nand_we_n` through the first cycle after its rising edge.
- R7: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 finish without sampling `nand_rb`. `done` comes at most 2 clocks after the last `nand_we_n` rise, even while `nand_rb` is 0.
- R8: All other opcodes sample `nand_rb` (1 = ready) no earlier than `TWB_CYC` clocks after the last `nand_we_n` rise. `TWB_CYC` is 5 at 50 MHz and 100 ns.
- R9: For reads (0x00, 0x01, 0x50) that carry a page address, `nand_ce_n` stays 0 from the second page byte until `done`, and it is 1 in the `done` cycle. Other opcodes leave `nand_ce_n` at 1 while waiting.
- R10: A read with a page address gives up waiting after `READ_WAIT_US` µs (1500 clocks by default) and raises `timeout` together with `done`. Reset (0xFF) and reads without a page address wait on `nand_rb` without a bound and end with `timeout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | sequencer idle, request can be taken |
| req_cmd | input | 8 | opcode |
| req_col_en | input | 1 | column address present |
| req_col | input | COL_W | column address |
| req_page_en | input | 1 | page address present |
| req_page | input | PAGE_W | page address |
| nand_rb | input | 1 | device ready (1) / busy (0) |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_ce_n | output | 1 | chip enable, active low |
| nand_we_n | output | 1 | write enable, active low |
| nand_dq | output | 8 | byte driven to the device |
| busy | output | 1 | request in progress |
| done | output | 1 | one-cycle completion pulse |
| timeout | output | 1 | bounded read wait expired, valid with done |

## Verification
The assertions assume that requests arrive only while the block is idle, and that a request's fields need not be held after it is taken. The bench drives `req_valid` for exactly one cycle while `req_ready` is high, so it never tests holding a request. `nand_rb` may change at any time, and the assertions take none of its timing for granted. The stimulus changes `nand_rb` only between clock edges: at fixed offsets, or never, to force the bounded-read timeout and the unbounded reset wait. The column sweep covers every column from 0 to 527 on both a byte-wide small-device configuration and a 16-bit large-device configuration.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PTR, ST_CMD, ST_COL, ST_PG0, ST_PG1, ST_PG2,
        ST_TWB, ST_WAIT, ST_DONE
    } seq_state_t;

    localparam logic [7:0] OP_RD_A      = 8'h00;
    localparam logic [7:0] OP_RD_B      = 8'h01;
    localparam logic [7:0] OP_RD_SPARE  = 8'h50;
    localparam logic [7:0] OP_LOAD      = 8'h80;
    localparam logic [7:0] OP_PROG      = 8'h10;
    localparam logic [7:0] OP_ER_SETUP  = 8'h60;
    localparam logic [7:0] OP_ER_GO     = 8'hD0;
    localparam logic [7:0] OP_STATUS    = 8'h70;

    function automatic logic op_is_read(input logic [7:0] op);
        return (op == OP_RD_A) || (op == OP_RD_B) || (op == OP_RD_SPARE);
    endfunction

    function automatic logic op_no_wait(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_ER_SETUP) || (op == OP_ER_GO) ||
               (op == OP_LOAD) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/nand_we_pulse.sv
module nand_we_pulse #(
    parameter int LOW_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic we_n,
    output logic last
);
    localparam int FRAME = LOW_CYC + 2;
    localparam int PH_W  = $clog2(FRAME);

    logic [PH_W-1:0] phase;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (!en || last)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    always_comb begin
        we_n = !(en && phase >= PH_W'(1) && phase <= PH_W'(LOW_CYC));
        last = en && (phase == PH_W'(LOW_CYC + 1));
    end

    // R6: a low strobe lasts at least two clocks
    assert_we_min_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |=> !we_n);

endmodule

// File: rtl/nand_cycle_timer.sv
module nand_cycle_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R8: once expired the timer stays expired until reloaded
    assert_timer_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int TWB_NS       = 100,
    parameter int READ_WAIT_US = 30,
    parameter int MAIN_BYTES   = 512,
    parameter int COL_W        = 10,
    parameter int PAGE_W       = 20,
    parameter bit BUS16        = 1'b0,
    parameter bit LARGE_DEV    = 1'b0,
    parameter int WE_LOW_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_cmd,
    input  logic              req_col_en,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_page_en,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              nand_rb,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_ce_n,
    output logic              nand_we_n,
    output logic [7:0]        nand_dq,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    localparam int TWB_CYC = (TWB_NS * CLK_MHZ + 999) / 1000;
    localparam int RD_CYC  = READ_WAIT_US * CLK_MHZ;
    localparam int TMAX    = (RD_CYC > TWB_CYC) ? RD_CYC : TWB_CYC;
    localparam int TMR_W   = $clog2(TMAX + 1);

    seq_state_t        state, nstate;
    logic [7:0]        cmd_q, ptr_q;
    logic [COL_W-1:0]  col_q;
    logic [PAGE_W-1:0] page_q;
    logic              col_en_q, page_en_q, ce_hold, to_q;

    logic [COL_W-1:0]  col_adj;
    logic [7:0]        ptr_op;
    seq_state_t        post_st;
    logic              byte_en, byte_last, tmr_zero, tmr_load, wait_expire;
    logic [TMR_W-1:0]  tmr_val;

    // column region selection for the pointer command
    always_comb begin
        col_adj = req_col;
        ptr_op  = OP_RD_A;
        if (req_cmd == OP_LOAD) begin
            if (req_col >= COL_W'(MAIN_BYTES)) begin
                col_adj = req_col - COL_W'(MAIN_BYTES);
                ptr_op  = OP_RD_SPARE;
            end else if (req_col >= COL_W'(256)) begin
                col_adj = req_col - COL_W'(256);
                ptr_op  = OP_RD_B;
            end
        end
        if (BUS16)
            col_adj = col_adj >> 1;
    end

    assign post_st     = op_no_wait(cmd_q) ? ST_DONE : ST_TWB;
    assign wait_expire = ce_hold && tmr_zero && !nand_rb;

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (req_valid) nstate = (req_cmd == OP_LOAD) ? ST_PTR : ST_CMD;
            ST_PTR:  if (byte_last) nstate = ST_CMD;
            ST_CMD:  if (byte_last) nstate = col_en_q ? ST_COL : (page_en_q ? ST_PG0 : post_st);
            ST_COL:  if (byte_last) nstate = page_en_q ? ST_PG0 : post_st;
            ST_PG0:  if (byte_last) nstate = ST_PG1;
            ST_PG1:  if (byte_last) nstate = LARGE_DEV ? ST_PG2 : post_st;
            ST_PG2:  if (byte_last) nstate = post_st;
            ST_TWB:  if (tmr_zero)  nstate = ST_WAIT;
            ST_WAIT: if (nand_rb || wait_expire) nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cmd_q     <= '0;
            ptr_q     <= '0;
            col_q     <= '0;
            page_q    <= '0;
            col_en_q  <= 1'b0;
            page_en_q <= 1'b0;
            ce_hold   <= 1'b0;
            to_q      <= 1'b0;
        end else begin
            state <= nstate;
            if (state == ST_IDLE && req_valid) begin
                cmd_q     <= req_cmd;
                ptr_q     <= ptr_op;
                col_q     <= col_adj;
                page_q    <= req_page;
                col_en_q  <= req_col_en;
                page_en_q <= req_page_en;
                to_q      <= 1'b0;
            end
            if (state == ST_PG0 && byte_last && op_is_read(cmd_q))
                ce_hold <= 1'b1;
            else if (nstate == ST_DONE)
                ce_hold <= 1'b0;
            if (state == ST_WAIT && !nand_rb && wait_expire)
                to_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        nand_cle  = (state == ST_PTR) || (state == ST_CMD);
        nand_ale  = (state == ST_COL) || (state == ST_PG0) ||
                    (state == ST_PG1) || (state == ST_PG2);
        byte_en   = nand_cle || nand_ale;
        nand_ce_n = !(byte_en || ce_hold);
        busy      = (state != ST_IDLE);
        req_ready = (state == ST_IDLE);
        done      = (state == ST_DONE);
        timeout   = done && to_q;
        unique case (state)
            ST_PTR:  nand_dq = ptr_q;
            ST_CMD:  nand_dq = cmd_q;
            ST_COL:  nand_dq = 8'(col_q);
            ST_PG0:  nand_dq = 8'(page_q);
            ST_PG1:  nand_dq = 8'(page_q >> 8);
            ST_PG2:  nand_dq = 8'(page_q >> 16) & 8'h0F;
            default: nand_dq = 8'h00;
        endcase
    end

    assign tmr_load = (nstate != state) && (nstate == ST_TWB || nstate == ST_WAIT);
    assign tmr_val  = (nstate == ST_TWB) ? TMR_W'(TWB_CYC) : TMR_W'(RD_CYC);

    nand_we_pulse #(.LOW_CYC(WE_LOW_CYC)) u_we (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (byte_en),
        .we_n (nand_we_n),
        .last (byte_last)
    );

    nand_cycle_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_we_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |-> (!nand_ce_n && (nand_cle || nand_ale)));

    assert_dq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_we_n |=> $stable(nand_dq));

    assert_done_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (req_ready && !busy));

    assert_timeout_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!busy && nand_ce_n && nand_we_n));

endmodule

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [7:0] req_cmd = 8'h00;
    logic req_col_en = 1'b0;
    logic [9:0] req_col = '0;
    logic req_page_en = 1'b0;
    logic [19:0] req_page = '0;
    logic rb = 1'b1;

    logic rdy_v[2], cle_v[2], ale_v[2], ce_v[2], we_v[2], busy_v[2], done_v[2], to_v[2];
    logic [7:0] dq_v[2];

    always #10 clk = ~clk;

    nand_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_v[0]),
        .req_cmd(req_cmd), .req_col_en(req_col_en), .req_col(req_col),
        .req_page_en(req_page_en), .req_page(req_page), .nand_rb(rb),
        .nand_cle(cle_v[0]), .nand_ale(ale_v[0]), .nand_ce_n(ce_v[0]),
        .nand_we_n(we_v[0]), .nand_dq(dq_v[0]), .busy(busy_v[0]),
        .done(done_v[0]), .timeout(to_v[0])
    );

    nand_cmd_seq #(.BUS16(1'b1), .LARGE_DEV(1'b1)) uut_w16 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_v[1]),
        .req_cmd(req_cmd), .req_col_en(req_col_en), .req_col(req_col),
        .req_page_en(req_page_en), .req_page(req_page), .nand_rb(rb),
        .nand_cle(cle_v[1]), .nand_ale(ale_v[1]), .nand_ce_n(ce_v[1]),
        .nand_we_n(we_v[1]), .nand_dq(dq_v[1]), .busy(busy_v[1]),
        .done(done_v[1]), .timeout(to_v[1])
    );

    localparam int TWB = 5;
    localparam int RDB = 1500;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_cyc = 0;

    logic [7:0] lg_b[2][8];
    logic lg_c[2][8], lg_a[2][8];
    int lg_n[2], low_run[2], last_rise[2], done_at[2], short_low[2];
    int ce_hi_gap[2], ce_lo_gap[2];
    logic done_seen[2], to_seen[2], ce_done[2], we_prev[2];

    logic [7:0] ex_b[8];
    logic ex_c[8];
    int ex_n;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (time %0t)", rq, act, exp, $time);
        end
    endtask

    // monitor of both instances
    always @(negedge clk) begin
        cyc++;
        for (int k = 0; k < 2; k++) begin
            if (rst_n) begin
                if (!we_prev[k] && we_v[k]) begin
                    if (lg_n[k] < 8) begin
                        lg_b[k][lg_n[k]] = dq_v[k];
                        lg_c[k][lg_n[k]] = cle_v[k];
                        lg_a[k][lg_n[k]] = ale_v[k];
                    end
                    lg_n[k]++;
                    last_rise[k] = cyc;
                    if (low_run[k] < 2) short_low[k]++;
                end
                low_run[k] = we_v[k] ? 0 : low_run[k] + 1;
                if (busy_v[k] && !done_v[k] && lg_n[k] > 0 && we_v[k] &&
                    !cle_v[k] && !ale_v[k]) begin
                    if (ce_v[k]) ce_hi_gap[k]++;
                    else ce_lo_gap[k]++;
                end
                if (done_v[k] && !done_seen[k]) begin
                    done_seen[k] = 1'b1;
                    done_at[k] = cyc;
                    to_seen[k] = to_v[k];
                    ce_done[k] = ce_v[k];
                end
            end
            we_prev[k] = we_v[k];
        end
    end

    task automatic build_exp(input int k, input logic [7:0] cmd, input bit cen,
                             input int col, input bit pen, input int page);
        int c;
        ex_n = 0;
        c = col;
        if (cmd == 8'h80) begin
            if (c >= 512) begin c -= 512; ex_b[ex_n] = 8'h50; end
            else if (c < 256) ex_b[ex_n] = 8'h00;
            else begin c -= 256; ex_b[ex_n] = 8'h01; end
            ex_c[ex_n] = 1'b1; ex_n++;
        end
        ex_b[ex_n] = cmd; ex_c[ex_n] = 1'b1; ex_n++;
        if (k == 1) c = c / 2;
        if (cen) begin ex_b[ex_n] = 8'(c); ex_c[ex_n] = 1'b0; ex_n++; end
        if (pen) begin
            ex_b[ex_n] = 8'(page & 'hFF); ex_c[ex_n] = 1'b0; ex_n++;
            ex_b[ex_n] = 8'((page >> 8) & 'hFF); ex_c[ex_n] = 1'b0; ex_n++;
            if (k == 1) begin
                ex_b[ex_n] = 8'((page >> 16) & 'hF); ex_c[ex_n] = 1'b0; ex_n++;
            end
        end
    endtask

    task automatic check_bytes(input string rq, input logic [7:0] cmd, input bit cen,
                               input int col, input bit pen, input int page);
        for (int k = 0; k < 2; k++) begin
            int bad;
            build_exp(k, cmd, cen, col, pen, page);
            bad = (lg_n[k] != ex_n) ? 1 : 0;
            for (int i = 0; i < ex_n && i < 8 && bad == 0; i++) begin
                if (lg_b[k][i] != ex_b[i] || lg_c[k][i] != ex_c[i] || lg_a[k][i] == ex_c[i]) begin
                    bad = 1;
                    chk(1'b0, rq, int'(lg_b[k][i]), int'(ex_b[i]));
                end
            end
            if (lg_n[k] != ex_n) chk(1'b0, rq, lg_n[k], ex_n);
            else if (bad == 0) chk(1'b1, rq, 0, 0);
            chk(short_low[k] == 0, "R6 short strobe", short_low[k], 0);
        end
    endtask

    task automatic run(input logic [7:0] cmd, input bit cen, input int col, input bit pen,
                       input int page, input int release_at, input int limit);
        int n;
        for (int k = 0; k < 2; k++) begin
            lg_n[k] = 0; done_seen[k] = 1'b0; to_seen[k] = 1'b0; ce_done[k] = 1'b0;
            ce_hi_gap[k] = 0; ce_lo_gap[k] = 0; short_low[k] = 0;
            done_at[k] = 0; last_rise[k] = 0;
        end
        rb = (release_at == 0);
        @(negedge clk); #1;
        req_cmd = cmd; req_col_en = cen; req_col = 10'(col);
        req_page_en = pen; req_page = 20'(page); req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
        acc_cyc = cyc;
        chk(busy_v[0] && !rdy_v[0] && busy_v[1] && !rdy_v[1], "R1 busy after accept",
            int'(busy_v[0]), 1);
        n = 0;
        while (!(done_seen[0] && done_seen[1]) && n < limit) begin
            @(negedge clk); #1;
            n++;
            if (n == release_at) rb = 1'b1;
        end
        @(negedge clk); #1;
        chk(rdy_v[0] && !busy_v[0] && rdy_v[1] && !busy_v[1], "R1 idle after done",
            int'(rdy_v[0]), 1);
    endtask

    initial begin
        #(150000 * 20);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            chk(rdy_v[k] && !busy_v[k] && !cle_v[k] && !ale_v[k] && ce_v[k] && we_v[k],
                "R1 reset state", int'(rdy_v[k]), 1);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R4 R5 R3 R7: full column sweep of the load command with rb held low
        for (int col = 0; col < 528; col++) begin
            run(8'h80, 1'b1, col, 1'b1, 'h3A5C7 ^ col, -1, 200);
            check_bytes("R4 pointer/column", 8'h80, 1'b1, col, 1'b1, 'h3A5C7 ^ col);
            for (int k = 0; k < 2; k++)
                chk(done_seen[k] && (done_at[k] - last_rise[k]) <= 2 && !to_seen[k],
                    "R7 load no wait", done_at[k] - last_rise[k], 1);
        end

        // R7 R2: no-wait opcodes with and without addresses
        run(8'h10, 1'b0, 0, 1'b0, 0, -1, 200);
        check_bytes("R2 prog cmd only", 8'h10, 1'b0, 0, 1'b0, 0);
        chk(done_seen[0] && done_at[0] - last_rise[0] <= 2, "R7 prog", done_at[0] - last_rise[0], 1);
        run(8'h60, 1'b0, 0, 1'b1, 'hF1234, -1, 200);
        check_bytes("R3 erase page only", 8'h60, 1'b0, 0, 1'b1, 'hF1234);
        chk(done_seen[1] && done_at[1] - last_rise[1] <= 2, "R7 erase", done_at[1] - last_rise[1], 1);
        run(8'hD0, 1'b0, 0, 1'b0, 0, -1, 200);
        check_bytes("R2 erase go", 8'hD0, 1'b0, 0, 1'b0, 0);
        run(8'h70, 1'b0, 0, 1'b0, 0, -1, 200);
        check_bytes("R2 status", 8'h70, 1'b0, 0, 1'b0, 0);
        chk(done_seen[0] && !to_seen[0], "R7 status", int'(done_seen[0]), 1);
        run(8'h90, 1'b1, 77, 1'b0, 0, 0, 200);
        check_bytes("R2 column only", 8'h90, 1'b1, 77, 1'b0, 0);

        // R9 R3 R5: reads with pages, rb released mid-wait
        for (int op = 0; op < 3; op++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] rc;
                int pg, cl;
                rc = (op == 0) ? 8'h00 : (op == 1) ? 8'h01 : 8'h50;
                pg = (p * 'h2F3B1 + 'h0055A) & 'hFFFFF;
                cl = (p * 71 + op * 13) & 'hFF;
                run(rc, 1'b1, cl, 1'b1, pg, 60, 400);
                check_bytes("R3 read address", rc, 1'b1, cl, 1'b1, pg);
                for (int k = 0; k < 2; k++) begin
                    chk(ce_hi_gap[k] == 0 && ce_lo_gap[k] > 0, "R9 ce held", ce_hi_gap[k], 0);
                    chk(ce_done[k] == 1'b1, "R9 ce released at done", int'(ce_done[k]), 1);
                    chk(done_seen[k] && !to_seen[k], "R10 read no timeout", int'(to_seen[k]), 0);
                end
            end
        end

        // R8: write-to-busy gap with rb already high
        run(8'h00, 1'b1, 5, 1'b1, 'h00123, 0, 200);
        for (int k = 0; k < 2; k++)
            chk(done_seen[k] && done_at[k] - last_rise[k] >= TWB, "R8 read tWB",
                done_at[k] - last_rise[k], TWB);
        run(8'hFF, 1'b0, 0, 1'b0, 0, 0, 200);
        for (int k = 0; k < 2; k++)
            chk(done_seen[k] && done_at[k] - last_rise[k] >= TWB, "R8 reset tWB",
                done_at[k] - last_rise[k], TWB);

        // R10: bounded read wait expires
        run(8'h01, 1'b1, 9, 1'b1, 'h4567, -1, 3000);
        for (int k = 0; k < 2; k++) begin
            chk(done_seen[k] && to_seen[k], "R10 timeout flag", int'(to_seen[k]), 1);
            chk(done_at[k] - last_rise[k] >= TWB + RDB, "R10 timeout bound",
                done_at[k] - last_rise[k], TWB + RDB);
        end

        // R10 R9: reset waits without bound and releases ce while waiting
        run(8'hFF, 1'b0, 0, 1'b0, 0, 2500, 4000);
        for (int k = 0; k < 2; k++) begin
            chk(done_seen[k] && done_at[k] - acc_cyc >= 2500 && !to_seen[k],
                "R10 reset unbounded", done_at[k] - acc_cyc, 2500);
            chk(ce_hi_gap[k] > 0 && ce_lo_gap[k] == 0, "R9 reset ce high", ce_lo_gap[k], 0);
        end

        // R10 R9: read without page address is unbounded and not held
        run(8'h00, 1'b1, 33, 1'b0, 0, 2000, 4000);
        check_bytes("R2 read column only", 8'h00, 1'b1, 33, 1'b0, 0);
        for (int k = 0; k < 2; k++) begin
            chk(done_seen[k] && done_at[k] - acc_cyc >= 2000 && !to_seen[k],
                "R10 read no page unbounded", done_at[k] - acc_cyc, 2000);
            chk(ce_lo_gap[k] == 0, "R9 no hold without page", ce_lo_gap[k], 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule